// File: doc/BRIEF.md
# Half-Port Pin Interrupt Channel

This block is one interrupt channel that watches up to 32 pins chosen from a wider set of device port pins. The pins are not picked one at a time: the channel's pins are split into groups of eight, and an assignment register names which eight-pin half port feeds each group. Each pin that reaches the channel is synchronized and then sensed by edge or by level, with a programmable active polarity. Detected events are held in a per-pin latch.

Software reads and writes the channel through a simple single-cycle register bus. The mask, sense-mode and polarity registers each have two addresses. Writing ones at the set address raises the selected bits. Writing ones at the clear address lowers them. Both addresses read back the register. The latches and the synchronized pin levels can always be read, whatever the mask holds. A single interrupt request output is raised while any latched pin is also unmasked. Software finds the pending pins and clears them one bit at a time.

Top module: `hpint_channel`

## Requirements
- R1: After reset the mask, sense-mode, polarity and latch registers read 0. The assignment register reads 32'h03020100, so group g takes half port g. irq_o is low.
- R2: Channel pins 8g+7..8g (group g) take port pins 8h+7..8h of pins_i. Here h is the value of bits [8g+2:8g] of the assignment register (address 8, read/write).
- R3: The level register (address 7, read-only) shows the synchronized channel pin levels. A change on pins_i shows there after the second rising clock edge.
- R4: With its sense bit at 1 (edge mode), a pin's latch bit is set only by a move into the active level. It becomes readable after the third rising edge that follows the pin change. Staying active or moving to inactive sets nothing.
- R5: With its sense bit at 0 (level mode), a pin's latch bit is set on every cycle the pin is active. A clear written while the pin stays active leaves the bit at 1.
- R6: Polarity bit 0 makes high the active level. Polarity bit 1 makes low the active level. A pin held at its inactive level never sets its latch.
- R7: Address pairs 0/1 (mask), 2/3 (sense mode) and 4/5 (polarity) are write-one-to-set / write-one-to-clear. Only the bits written as 1 change. Either address of a pair reads the register.
- R8: The latch register (address 6) reads the latched requests regardless of the mask. Writing ones there clears only those bits. A set in the same cycle wins over the clear.
- R9: The request register (address 9, read-only) equals latch AND mask. irq_o is high exactly when it is nonzero. It follows a mask write from the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 64 | Raw port pins, eight half ports of eight pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_o | output | 1 | Channel interrupt request |

## Verification
A pin change reaches the level register after two rising edges and the latch after three. A register write takes effect at the edge that accepts it, so irq_o and the request register follow a mask write at once. The bench drives inputs two nanoseconds after an edge. It counts edges to those exact depths before sampling, and it checks one step early where the latency itself is the point. Near-exhaustive sweeps cover every group against every half port and every pin in all four sense/polarity combinations.

// File: rtl/hpint_pkg.sv
package hpint_pkg;
    localparam int HALF_W = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK_SET = 4'd0,
        RA_MASK_CLR = 4'd1,
        RA_MODE_SET = 4'd2,
        RA_MODE_CLR = 4'd3,
        RA_POL_SET  = 4'd4,
        RA_POL_CLR  = 4'd5,
        RA_LATCH    = 4'd6,
        RA_LEVEL    = 4'd7,
        RA_ASSIGN   = 4'd8,
        RA_REQ      = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/hpint_select.sv
module hpint_select #(
    parameter int NUM_HALF = 8,
    parameter int N_GROUPS = 4,
    localparam int SEL_W   = $clog2(NUM_HALF),
    localparam int CH      = N_GROUPS * hpint_pkg::HALF_W
) (
    input  logic [NUM_HALF*hpint_pkg::HALF_W-1:0] pins_i,
    input  logic [N_GROUPS*SEL_W-1:0]             sel_i,
    output logic [CH-1:0]                         grp_o
);
    import hpint_pkg::*;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic [HALF_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int h = 0; h < NUM_HALF; h++) begin
                if (sel_i[g*SEL_W +: SEL_W] == SEL_W'(h)) begin
                    pick = pins_i[h*HALF_W +: HALF_W];
                end
            end
        end
        assign grp_o[g*HALF_W +: HALF_W] = pick;
    end
endmodule

// File: rtl/hpint_sync.sv
module hpint_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] lvl_d_o
);
    logic [WIDTH-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o   = s2_q;
    assign lvl_d_o = s3_q;
endmodule

// File: rtl/hpint_detect.sv
module hpint_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] lvl_d_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] inv_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] latch_o
);
    logic [WIDTH-1:0] act_v, rise_v, set_v;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic act, act_d, setp, lat_q;
        assign act   = lvl_i[i] ^ inv_i[i];
        assign act_d = lvl_d_i[i] ^ inv_i[i];
        assign setp  = edge_mode_i[i] ? (act & ~act_d) : act;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat_q <= 1'b0;
            else        lat_q <= (lat_q & ~clr_i[i]) | setp;
        end

        assign act_v[i]   = act;
        assign rise_v[i]  = act & ~act_d;
        assign set_v[i]   = setp;
        assign latch_o[i] = lat_q;
    end

    // R4: in edge mode a latch bit only rises after a move into the active level
    a_r4_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_o & ~$past(latch_o) & $past(edge_mode_i) & ~$past(rise_v)) == '0));

    // R5: in level mode an active pin leaves its latch bit at 1
    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(act_v & ~edge_mode_i) & ~latch_o) == '0));

    // R8: a clear with no simultaneous set empties the bit
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_o & $past(clr_i & ~set_v)) == '0));
endmodule

// File: rtl/hpint_regs.sv
module hpint_regs #(
    parameter int NUM_HALF = 8,
    parameter int N_GROUPS = 4,
    localparam int SEL_W   = $clog2(NUM_HALF),
    localparam int CH      = N_GROUPS * hpint_pkg::HALF_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic [hpint_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [hpint_pkg::DATA_W-1:0]  bus_wdata,
    output logic [hpint_pkg::DATA_W-1:0]  bus_rdata,
    input  logic [CH-1:0]                 latch_i,
    input  logic [CH-1:0]                 lvl_i,
    output logic [CH-1:0]                 mask_o,
    output logic [CH-1:0]                 mode_o,
    output logic [CH-1:0]                 inv_o,
    output logic [CH-1:0]                 clr_o,
    output logic [N_GROUPS*SEL_W-1:0]     sel_o
);
    import hpint_pkg::*;

    logic [CH-1:0]    mask_q, mode_q, inv_q;
    logic [SEL_W-1:0] sel_q [N_GROUPS];
    logic [CH-1:0]    wbits;
    reg_addr_e        addr_e;

    assign wbits  = bus_wdata[CH-1:0];
    assign addr_e = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
            inv_q  <= '0;
        end else if (bus_we) begin
            unique case (addr_e)
                RA_MASK_SET: mask_q <= mask_q | wbits;
                RA_MASK_CLR: mask_q <= mask_q & ~wbits;
                RA_MODE_SET: mode_q <= mode_q | wbits;
                RA_MODE_CLR: mode_q <= mode_q & ~wbits;
                RA_POL_SET:  inv_q  <= inv_q | wbits;
                RA_POL_CLR:  inv_q  <= inv_q & ~wbits;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[g] <= SEL_W'(g % NUM_HALF);
            end else if (bus_we && addr_e == RA_ASSIGN) begin
                sel_q[g] <= bus_wdata[g*HALF_W +: SEL_W];
            end
        end
        assign sel_o[g*SEL_W +: SEL_W] = sel_q[g];
    end

    assign clr_o  = (bus_we && addr_e == RA_LATCH) ? wbits : '0;
    assign mask_o = mask_q;
    assign mode_o = mode_q;
    assign inv_o  = inv_q;

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e)
            RA_MASK_SET, RA_MASK_CLR: bus_rdata = DATA_W'(mask_q);
            RA_MODE_SET, RA_MODE_CLR: bus_rdata = DATA_W'(mode_q);
            RA_POL_SET,  RA_POL_CLR:  bus_rdata = DATA_W'(inv_q);
            RA_LATCH:                 bus_rdata = DATA_W'(latch_i);
            RA_LEVEL:                 bus_rdata = DATA_W'(lvl_i);
            RA_REQ:                   bus_rdata = DATA_W'(latch_i & mask_q);
            RA_ASSIGN: begin
                for (int g = 0; g < N_GROUPS; g++) begin
                    bus_rdata[g*HALF_W +: HALF_W] = HALF_W'(sel_q[g]);
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    // R7: set alias raises every written-one bit
    a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_e == RA_MASK_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R7: clear alias lowers every written-one bit and keeps the rest
    a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_e == RA_MASK_CLR) |=>
            (((mask_q & $past(wbits)) == '0) && ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits)))));
endmodule

// File: rtl/hpint_channel.sv
module hpint_channel #(
    parameter int NUM_HALF = 8,
    parameter int N_GROUPS = 4,
    localparam int SEL_W   = $clog2(NUM_HALF),
    localparam int CH      = N_GROUPS * hpint_pkg::HALF_W,
    localparam int PIN_W   = NUM_HALF * hpint_pkg::HALF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PIN_W-1:0]             pins_i,
    input  logic                         bus_we,
    input  logic [hpint_pkg::ADDR_W-1:0] bus_addr,
    input  logic [hpint_pkg::DATA_W-1:0] bus_wdata,
    output logic [hpint_pkg::DATA_W-1:0] bus_rdata,
    output logic                         irq_o
);
    logic [CH-1:0]             grp, lvl, lvl_d, mask, mode, inv, clr, latch;
    logic [N_GROUPS*SEL_W-1:0] sel;

    hpint_select #(.NUM_HALF(NUM_HALF), .N_GROUPS(N_GROUPS)) u_select (
        .pins_i (pins_i),
        .sel_i  (sel),
        .grp_o  (grp)
    );

    hpint_sync #(.WIDTH(CH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (grp),
        .lvl_o   (lvl),
        .lvl_d_o (lvl_d)
    );

    hpint_detect #(.WIDTH(CH)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (lvl),
        .lvl_d_i     (lvl_d),
        .edge_mode_i (mode),
        .inv_i       (inv),
        .clr_i       (clr),
        .latch_o     (latch)
    );

    hpint_regs #(.NUM_HALF(NUM_HALF), .N_GROUPS(N_GROUPS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .latch_i   (latch),
        .lvl_i     (lvl),
        .mask_o    (mask),
        .mode_o    (mode),
        .inv_o     (inv),
        .clr_o     (clr),
        .sel_o     (sel)
    );

    assign irq_o = |(latch & mask);

    // R9: an all-zero mask keeps the request low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R1: reset leaves the request low
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/hpint_channel_bench.sv
module hpint_channel_bench;
    localparam int NH = 8;
    localparam int NG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pins = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hpint_channel #(.NUM_HALF(NH), .N_GROUPS(NG)) u_hpint_channel (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #2;
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] pat(input int h);
        return 8'(h * 8'h35 + 8'h1C);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(4'd0, v); chk("R1 mask", v, 32'h0);
        rd(4'd2, v); chk("R1 mode", v, 32'h0);
        rd(4'd4, v); chk("R1 polarity", v, 32'h0);
        rd(4'd6, v); chk("R1 latch", v, 32'h0);
        rd(4'd8, v); chk("R1 assign", v, 32'h03020100);
        chk("R1 irq", 32'(irq), 32'h0);

        // R7 set/clear aliases
        wr(4'd0, 32'hF0F0_0F0F);
        rd(4'd1, v); chk("R7 mask set", v, 32'hF0F0_0F0F);
        wr(4'd1, 32'h0000_FFFF);
        rd(4'd0, v); chk("R7 mask clr", v, 32'hF0F0_0000);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'h0000_00A5);
        wr(4'd3, 32'h0000_0005);
        rd(4'd2, v); chk("R7 mode pair", v, 32'h0000_00A0);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'h8000_0001);
        rd(4'd5, v); chk("R7 polarity pair", v, 32'h8000_0001);
        wr(4'd5, 32'hFFFF_FFFF);
        tick(4);
        wr(4'd6, 32'hFFFF_FFFF);

        // R3 latency of the level register
        pins = 64'h0000_0000_1234_5678;
        tick(1);
        rd(4'd7, v); chk("R3 level one edge", v, 32'h0);
        tick(1);
        rd(4'd7, v); chk("R3 level two edges", v, 32'h1234_5678);

        // R2 every group against every half port
        for (int h = 0; h < NH; h++) pins[h*8 +: 8] = pat(h);
        for (int g = 0; g < NG; g++) begin
            for (int h = 0; h < NH; h++) begin
                logic [31:0] asg, exp;
                asg = 32'h03020100;
                asg[g*8 +: 8] = 8'(h);
                exp = '0;
                for (int k = 0; k < NG; k++) exp[k*8 +: 8] = pat(int'(asg[k*8 +: 8]));
                wr(4'd8, asg);
                tick(2);
                rd(4'd7, v); chk("R2 group select", v, exp);
            end
        end
        wr(4'd8, 32'h03020100);
        pins = '0;
        tick(4);
        wr(4'd6, 32'hFFFF_FFFF);

        // R4 R5 R6 R8 R9 per pin, every sense/polarity mix
        for (int i = 0; i < 32; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic edg, pol;
                logic [31:0] bit_i;
                edg = m[0];
                pol = m[1];
                bit_i = 32'h1 << i;
                pins[i] = pol;
                if (edg) wr(4'd2, bit_i);
                if (pol) wr(4'd4, bit_i);
                tick(4);
                wr(4'd6, 32'hFFFF_FFFF);
                tick(1);
                rd(4'd6, v); chk("R6 inactive level sets nothing", v, 32'h0);

                pins[i] = ~pol;
                tick(2);
                if (i == 0) begin
                    rd(4'd6, v); chk("R4 latch not before third edge", v, 32'h0);
                end
                tick(1);
                rd(4'd6, v); chk(edg ? "R4 edge latched" : "R5 level latched", v, bit_i);

                if (m == 0) begin
                    chk("R9 masked irq low", 32'(irq), 32'h0);
                    wr(4'd0, bit_i);
                    chk("R9 unmasked irq high", 32'(irq), 32'h1);
                    rd(4'd9, v); chk("R9 request reg", v, bit_i);
                    wr(4'd1, bit_i);
                    chk("R9 remasked irq low", 32'(irq), 32'h0);
                    rd(4'd6, v); chk("R8 latch visible while masked", v, bit_i);
                end

                wr(4'd6, bit_i);
                rd(4'd6, v);
                chk(edg ? "R4 held active no re-set" : "R5 clear loses to active level",
                    v, edg ? 32'h0 : bit_i);

                pins[i] = pol;
                tick(3);
                rd(4'd6, v);
                chk(edg ? "R4 leaving active sets nothing" : "R5 latch kept after release",
                    v, edg ? 32'h0 : bit_i);
                wr(4'd6, bit_i);
                rd(4'd6, v); chk("R8 write-one clears", v, 32'h0);

                pins[i] = 1'b0;
                wr(4'd3, 32'hFFFF_FFFF);
                wr(4'd5, 32'hFFFF_FFFF);
                tick(4);
                wr(4'd6, 32'hFFFF_FFFF);
            end
        end

        finish_run();
    end
endmodule